// File: doc/BRIEF.md
# Processor Status and Control Flag Register

This block keeps the status word of a 16-bit processor core. On each cycle where the update strobe is high, it derives the six condition flags from the ALU operands, the ALU result, the operation class and the operand size. Those flags are carry, parity, half carry, zero, sign and overflow. The three control flags are single-step, interrupt enable and string direction. Software sets or clears them through per-bit request vectors.

A whole-word load, as used when the status word is restored from the stack, replaces all nine defined bits in one cycle. The block presents the 16-bit status word, and it drives the three control flags out on separate pins for the sequencer.

The block does not decode instructions, compute the ALU result, sequence interrupts or step addresses. It only records and presents flags. The flag register has no sequencing of its own, so it has no state machine. The two registers are the condition-flag register and the control-flag register.

Top module: `status_flag_reg`

## Requirements
- R1: Word layout: carry bit 0, parity bit 2, half carry bit 4, zero bit 6, sign bit 7, single-step bit 8, interrupt enable bit 9, direction bit 10, overflow bit 11. Every other bit reads a fixed pattern, which is 16'h0002 (bit 1 reads 1), and loads do not change it.
- R2: While `rst_n` is low, all nine defined flags are cleared, so the status word reads 16'h0002.
- R3: On an update, parity becomes 1 when `alu_res[7:0]` holds an even number of ones and 0 when it holds an odd number, in both byte and word mode.
- R4: On an update, zero tests only the active width (bits 7:0 when `word_sz`=0, bits 15:0 when 1). Sign takes bit 7 or bit 15 of the result to match the width.
- R5: Carry is the carry out of the top active bit when `op_class`=0 (add) and the borrow out of that bit when `op_class`=1 (subtract).
- R6: For add, overflow is set when both operands have equal signs and the result's sign differs from them. For subtract, it is set when the operand signs differ and the result's sign differs from the first operand's sign.
- R7: For add and subtract, half carry is the carry or borrow from bit 3 into bit 4. For a logic class (`op_class` 2 or 3), it keeps its old value.
- R8: A logic-class update clears carry and overflow.
- R9: On a cycle with `upd_en` low, the six condition flags keep their values.
- R10: For each bit of `ctl_set`/`ctl_clr` (bit 0 single-step, bit 1 interrupt enable, bit 2 direction), a request changes the matching flag at the next clock edge. A clear wins over a set of the same flag in the same cycle.
- R11: `step_o`, `int_en_o` and `dir_o` follow the single-step, interrupt-enable and direction bits of the status word at all times.
- R12: When `load_en` is high, the nine defined bits take the matching bits of `load_val` at the next edge. This has priority over a same-cycle update and over set or clear requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Condition-flag update strobe |
| op_class | input | 2 | 0 add, 1 subtract, 2 or 3 logic |
| word_sz | input | 1 | 1 word operands, 0 byte operands |
| opa | input | 16 | First ALU operand (minuend for subtract) |
| opb | input | 16 | Second ALU operand |
| alu_res | input | 16 | ALU result |
| ctl_set | input | 3 | Set requests for the control flags |
| ctl_clr | input | 3 | Clear requests for the control flags |
| load_en | input | 1 | Whole-word load strobe |
| load_val | input | 16 | Word to load |
| flags | output | 16 | Status word |
| step_o | output | 1 | Single-step flag |
| int_en_o | output | 1 | Interrupt enable flag |
| dir_o | output | 1 | String direction flag |

## Verification
The hardest case to reach is three demands in one cycle: a word load, an ALU update, and set and clear requests on the same control flag. Only the load may take effect, and the half-carry value the load supplies must persist through a following logic update. Directed cycles build exactly this overlap and then run a logic operation. A long random stretch also raises `load_en`, `upd_en` and both request vectors independently. The bench compares every field against its model on every cycle, with operand sign and nibble patterns chosen so each overflow and half-carry combination appears.

// File: rtl/flag_pkg.sv
package flag_pkg;
    localparam int WORD_W    = 16;
    localparam int CTRL_N    = 3;
    localparam int B_CARRY   = 0;
    localparam int B_PARITY  = 2;
    localparam int B_HALF    = 4;
    localparam int B_ZERO    = 6;
    localparam int B_SIGN    = 7;
    localparam int B_STEP    = 8;
    localparam int B_INTEN   = 9;
    localparam int B_DIR     = 10;
    localparam int B_OVFL    = 11;
    localparam logic [WORD_W-1:0] FIXED_PATTERN = 16'h0002;
    localparam logic [WORD_W-1:0] DEFINED_MASK  = 16'h0FD5;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_LOGIC = 2'd2,
        OP_LOGX  = 2'd3
    } op_class_e;

    typedef struct packed {
        logic ovfl;
        logic sign;
        logic zero;
        logic half;
        logic parity;
        logic carry;
    } cond_t;

    typedef struct packed {
        logic dir;
        logic inten;
        logic step;
    } ctrl_t;
endpackage

// File: rtl/flag_arith.sv
module flag_arith
    import flag_pkg::*;
#(
    parameter int W = 16
) (
    input  op_class_e    op,
    input  logic         word_sz,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         half_prev,
    output cond_t        nxt
);
    localparam int BW = W / 2;

    logic a_top, b_top, r_top;
    logic is_zero;

    always_comb begin
        if (word_sz) begin
            a_top   = a[W-1];
            b_top   = b[W-1];
            r_top   = r[W-1];
            is_zero = (r == '0);
        end else begin
            a_top   = a[BW-1];
            b_top   = b[BW-1];
            r_top   = r[BW-1];
            is_zero = (r[BW-1:0] == '0);
        end
    end

    always_comb begin
        nxt.parity = ~^r[7:0];
        nxt.zero   = is_zero;
        nxt.sign   = r_top;
        nxt.half   = half_prev;
        nxt.carry  = 1'b0;
        nxt.ovfl   = 1'b0;
        unique case (op)
            OP_ADD: begin
                nxt.carry = (a_top & b_top) | ((a_top | b_top) & ~r_top);
                nxt.ovfl  = (a_top == b_top) && (r_top != a_top);
                nxt.half  = a[4] ^ b[4] ^ r[4];
            end
            OP_SUB: begin
                nxt.carry = (~a_top & b_top) | ((~a_top | b_top) & r_top);
                nxt.ovfl  = (a_top != b_top) && (r_top != a_top);
                nxt.half  = a[4] ^ b[4] ^ r[4];
            end
            OP_LOGIC, OP_LOGX: begin
                nxt.carry = 1'b0;
                nxt.ovfl  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    input  logic         load_en,
    input  logic [N-1:0] load_bits,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (load_en)
                q[i] <= load_bits[i];
            else if (clr_req[i])
                q[i] <= 1'b0;
            else if (set_req[i])
                q[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import flag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_en,
    input  logic [1:0]  op_class,
    input  logic        word_sz,
    input  logic [15:0] opa,
    input  logic [15:0] opb,
    input  logic [15:0] alu_res,
    input  logic [2:0]  ctl_set,
    input  logic [2:0]  ctl_clr,
    input  logic        load_en,
    input  logic [15:0] load_val,
    output logic [15:0] flags,
    output logic        step_o,
    output logic        int_en_o,
    output logic        dir_o
);
    cond_t cond_q, cond_nxt, cond_load;
    ctrl_t ctrl_q;
    logic [CTRL_N-1:0] ctrl_load;

    flag_arith #(.W(WORD_W)) u_arith (
        .op        (op_class_e'(op_class)),
        .word_sz   (word_sz),
        .a         (opa),
        .b         (opb),
        .r         (alu_res),
        .half_prev (cond_q.half),
        .nxt       (cond_nxt)
    );

    always_comb begin
        cond_load.carry  = load_val[B_CARRY];
        cond_load.parity = load_val[B_PARITY];
        cond_load.half   = load_val[B_HALF];
        cond_load.zero   = load_val[B_ZERO];
        cond_load.sign   = load_val[B_SIGN];
        cond_load.ovfl   = load_val[B_OVFL];
        ctrl_load        = {load_val[B_DIR], load_val[B_INTEN], load_val[B_STEP]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cond_q <= '0;
        else if (load_en)
            cond_q <= cond_load;
        else if (upd_en)
            cond_q <= cond_nxt;
    end

    flag_ctrl #(.N(CTRL_N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (ctl_set),
        .clr_req   (ctl_clr),
        .load_en   (load_en),
        .load_bits (ctrl_load),
        .q         (ctrl_q)
    );

    always_comb begin
        flags           = FIXED_PATTERN;
        flags[B_CARRY]  = cond_q.carry;
        flags[B_PARITY] = cond_q.parity;
        flags[B_HALF]   = cond_q.half;
        flags[B_ZERO]   = cond_q.zero;
        flags[B_SIGN]   = cond_q.sign;
        flags[B_OVFL]   = cond_q.ovfl;
        flags[B_STEP]   = ctrl_q.step;
        flags[B_INTEN]  = ctrl_q.inten;
        flags[B_DIR]    = ctrl_q.dir;
    end

    assign step_o   = ctrl_q.step;
    assign int_en_o = ctrl_q.inten;
    assign dir_o    = ctrl_q.dir;
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk
    import flag_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        upd_en,
    input logic [1:0]  op_class,
    input logic [15:0] alu_res,
    input logic [2:0]  ctl_set,
    input logic [2:0]  ctl_clr,
    input logic        load_en,
    input logic [15:0] load_val,
    input logic [15:0] flags
);
    localparam logic [15:0] COND_MASK = 16'h08D5;
    localparam logic [15:0] CTRL_MASK = 16'h0700;

    // R1
    a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~DEFINED_MASK) == FIXED_PATTERN);

    // R3
    a_r3_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en) |=> flags[B_PARITY] == ($countones($past(alu_res[7:0])) % 2 == 0));

    // R8
    a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en && op_class[1]) |=> (!flags[B_CARRY] && !flags[B_OVFL]));

    // R9
    a_r9_hold_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !load_en) |=> $stable(flags & COND_MASK));

    // R10
    a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == 3'b000 && ctl_clr == 3'b000 && !load_en) |=> $stable(flags & CTRL_MASK));

    // R10
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && ctl_clr[0]) |=> !flags[B_STEP]);

    // R12
    a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (flags & DEFINED_MASK) == ($past(load_val) & DEFINED_MASK));
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .op_class (op_class),
    .alu_res  (alu_res),
    .ctl_set  (ctl_set),
    .ctl_clr  (ctl_clr),
    .load_en  (load_en),
    .load_val (load_val),
    .flags    (flags)
);

// File: tb/status_flag_reg_tb.sv
module status_flag_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic        word_sz = 1'b0;
    logic [15:0] opa = '0, opb = '0, alu_res = '0;
    logic [2:0]  ctl_set = '0, ctl_clr = '0;
    logic        load_en = 1'b0;
    logic [15:0] load_val = '0;
    logic [15:0] flags;
    logic        step_o, int_en_o, dir_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string phase = "R2 reset";

    // reference state
    bit m_cf, m_pf, m_af, m_zf, m_sf, m_of, m_tf, m_if, m_df;

    status_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
        .word_sz(word_sz), .opa(opa), .opb(opb), .alu_res(alu_res),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .load_en(load_en),
        .load_val(load_val), .flags(flags), .step_o(step_o),
        .int_en_o(int_en_o), .dir_o(dir_o)
    );

    always #2.5 clk = ~clk;

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        int w, msk, a, b, r, sa, sb, sr;
        cyc = cyc + 1;
        if (!rst_n) begin
            {m_cf, m_pf, m_af, m_zf, m_sf, m_of, m_tf, m_if, m_df} = '0;
        end else if (load_en) begin
            m_cf = load_val[0];  m_pf = load_val[2];  m_af = load_val[4];
            m_zf = load_val[6];  m_sf = load_val[7];  m_tf = load_val[8];
            m_if = load_val[9];  m_df = load_val[10]; m_of = load_val[11];
        end else begin
            if (upd_en) begin
                w   = word_sz ? 16 : 8;
                msk = (1 << w) - 1;
                a = int'(opa) & msk; b = int'(opb) & msk; r = int'(alu_res) & msk;
                sa = (a >> (w - 1)) & 1; sb = (b >> (w - 1)) & 1; sr = (r >> (w - 1)) & 1;
                m_pf = ($countones(alu_res[7:0]) % 2) == 0;
                m_zf = (r == 0);
                m_sf = sr[0];
                if (op_class == 2'd0) begin
                    m_cf = (((a + b) >> w) & 1) != 0;
                    m_of = (sa == sb) && (sr != sa);
                    m_af = (((a ^ b ^ r) >> 4) & 1) != 0;
                end else if (op_class == 2'd1) begin
                    m_cf = a < b;
                    m_of = (sa != sb) && (sr != sa);
                    m_af = (((a ^ b ^ r) >> 4) & 1) != 0;
                end else begin
                    m_cf = 1'b0;
                    m_of = 1'b0;
                end
            end
            if (ctl_clr[0]) m_tf = 1'b0; else if (ctl_set[0]) m_tf = 1'b1;
            if (ctl_clr[1]) m_if = 1'b0; else if (ctl_set[1]) m_if = 1'b1;
            if (ctl_clr[2]) m_df = 1'b0; else if (ctl_set[2]) m_df = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) cycle %0d: got %h expected %h", tag, phase, cyc, got, exp);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        chk("R1 fixed bits", flags & 16'hF02A, 16'h0002);
        chk("R5 carry", {15'b0, flags[0]}, {15'b0, m_cf});
        chk("R3 parity", {15'b0, flags[2]}, {15'b0, m_pf});
        chk("R7 half carry", {15'b0, flags[4]}, {15'b0, m_af});
        chk("R4 zero/sign", {14'b0, flags[7], flags[6]}, {14'b0, m_sf, m_zf});
        chk("R6 overflow", {15'b0, flags[11]}, {15'b0, m_of});
        chk("R10 control", {13'b0, flags[10:8]}, {13'b0, m_df, m_if, m_tf});
        chk("R11 pins", {13'b0, dir_o, int_en_o, step_o}, {13'b0, m_df, m_if, m_tf});
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired: got %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic alu(input logic [1:0] op, input logic wd, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        upd_en = 1'b1; op_class = op; word_sz = wd; opa = a; opb = b;
        case (op)
            2'd0: alu_res = a + b;
            2'd1: alu_res = a - b;
            2'd2: alu_res = a & b;
            default: alu_res = a ^ b;
        endcase
    endtask

    task automatic idle();
        @(negedge clk);
        upd_en = 1'b0; load_en = 1'b0; ctl_set = '0; ctl_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R5 R3 R4 byte add";
        alu(2'd0, 1'b0, 16'h12FF, 16'h0001);   // byte wraps to zero, upper byte ignored
        alu(2'd0, 1'b0, 16'h0008, 16'h0008);   // half carry
        phase = "R6 word add";
        alu(2'd0, 1'b1, 16'h7FFF, 16'h0001);   // signed overflow, sign set
        alu(2'd0, 1'b1, 16'h8000, 16'h8000);   // carry and overflow, zero
        phase = "R5 R6 subtract";
        alu(2'd1, 1'b1, 16'h0000, 16'h0001);   // borrow
        alu(2'd1, 1'b0, 16'h0080, 16'h0001);   // byte overflow
        alu(2'd1, 1'b1, 16'h8000, 16'h7FFF);   // word overflow
        alu(2'd1, 1'b0, 16'h0010, 16'h0001);   // half borrow
        phase = "R8 R7 logic";
        alu(2'd2, 1'b1, 16'hF0F0, 16'h0F0F);
        alu(2'd3, 1'b0, 16'h00A5, 16'h0024);
        phase = "R9 hold";
        idle();
        opa = 16'h1234; opb = 16'hFFFF; alu_res = 16'h0000; op_class = 2'd0;
        repeat (3) @(negedge clk);
        phase = "R10 set clear";
        ctl_set = 3'b111;
        @(negedge clk); ctl_set = 3'b000; ctl_clr = 3'b010;
        @(negedge clk); ctl_set = 3'b101; ctl_clr = 3'b101;   // clear wins
        idle();
        phase = "R12 load priority";
        alu(2'd0, 1'b1, 16'hFFFF, 16'h0001);
        load_en = 1'b1; load_val = 16'hFFFF; ctl_clr = 3'b111;
        @(negedge clk); load_en = 1'b1; load_val = 16'h0000; ctl_set = 3'b111; ctl_clr = 3'b000;
        @(negedge clk); load_val = 16'h0810;
        idle();
        alu(2'd2, 1'b1, 16'h0000, 16'h0000);   // half carry from load must survive
        idle();
        phase = "R12 R10 random";
        for (int i = 0; i < 3000; i++) begin
            alu(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                16'($urandom), 16'($urandom));
            upd_en   = ($urandom_range(0, 3) != 0);
            load_en  = ($urandom_range(0, 9) == 0);
            load_val = 16'($urandom);
            ctl_set  = 3'($urandom);
            ctl_clr  = 3'($urandom) & 3'($urandom);
        end
        idle();
        @(negedge clk);
        phase = "R2 reset again";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule